// File: doc/BRIEF.md
# Dual Retriggerable Digital One-Shot

This block holds two independent pulse generators, each timed by the system clock. Each channel watches three synchronous control inputs: a falling-edge trigger, a rising-edge trigger and an active-low clear. When a valid trigger edge is seen, the channel raises its true output for a number of clock cycles given by that channel's width input. The width is sampled at the moment of the trigger. The complementary output is always the inverse of the true output.

Each trigger input is gated by the other one. A falling edge on the first input counts only while the second input is high. A rising edge on the second input counts only while the first input is low. A trigger that arrives during a pulse loads the full width again, so a steady train of triggers can keep the output high without a break. Pulling the clear low ends a pulse and blocks triggers for as long as it stays low. Releasing the clear while the first input is low and the second is high starts a new pulse.

Each input is registered once. An edge is found by comparing that registered value with the value registered one cycle before. The pulse counter is loaded on the clock edge after the one that captured the input change.

Top module: `dual_oneshot`

## Requirements
- R1: With the channel's registered `b` high, a high-to-low change of `a` starts a pulse. If `b` is low, the same change has no effect.
- R2: With the channel's registered `a` low, a low-to-high change of `b` starts a pulse. If `a` is high, the same change has no effect.
- R3: A trigger during an active pulse reloads the full width. Triggers spaced closer than the width keep `q` high without a gap until width cycles after the last trigger.
- R4: While `clr_n` is low, the pulse ends on the next counter update and every trigger is ignored. If clear and a trigger arrive in the same cycle, the clear wins.
- R5: A low-to-high change of `clr_n` starts a pulse when `a` is low and `b` is high.
- R6: An input change captured at clock edge k makes `q` high from edge k+1. `q` then stays high for exactly the sampled width in cycles. `qn` is always the inverse of `q`: low while a pulse is active and high while idle.
- R7: A trigger that samples a width of zero produces no pulse. If a pulse is active at that moment, it ends.
- R8: The two channels share only the clock and reset. Activity on one channel never changes the outputs of the other.
- R9: During `rst_ni` low, `q` is 0 and `qn` is 1. The stored input history takes the values a=1, b=0, clr_n=1, and edges after reset are measured against these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | NUM_CH | Falling-edge trigger, one bit per channel |
| b_i | input | NUM_CH | Rising-edge trigger, one bit per channel |
| clr_ni | input | NUM_CH | Active-low clear, one bit per channel |
| width_i | input | NUM_CH*WIDTH_W | Pulse width in cycles; channel c uses bits [c*WIDTH_W +: WIDTH_W] |
| q_o | output | NUM_CH | True pulse output per channel |
| qn_o | output | NUM_CH | Complementary pulse output per channel |

## Verification
The bench builds the block with two channels and an 8-bit width. Directed tests then cover three boundary cases: zero widths, short widths, and widths long enough to overlap with retriggers. A cycle-level behavioural model runs next to the design, so every output cycle of both channels is compared. This includes a long stretch of random triggering, clearing and width changes, which reaches clear/trigger collisions and concurrent activity on both channels.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic a;
    logic b;
    logic clr;
  } trig_in_t;

  localparam trig_in_t IDLE_HIST = '{a: 1'b1, b: 1'b0, clr: 1'b1};
endpackage

// File: rtl/os_trig_detect.sv
module os_trig_detect
  import oneshot_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  trig_in_t in_i,
  output logic     fire_o,
  output logic     hold_o
);
  trig_in_t cur_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= IDLE_HIST;
      prv_q <= IDLE_HIST;
    end else begin
      prv_q <= cur_q;
      cur_q <= in_i;
    end
  end

  logic a_fall, b_rise, clr_rise;
  assign a_fall   = prv_q.a & ~cur_q.a & cur_q.b;
  assign b_rise   = ~prv_q.b & cur_q.b & ~cur_q.a;
  assign clr_rise = ~prv_q.clr & ~cur_q.a & cur_q.b;

  // clear level gates every trigger source
  assign fire_o = cur_q.clr & (a_fall | b_rise | clr_rise);
  assign hold_o = cur_q.clr;
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int WIDTH_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               hold_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               active_o
);
  localparam logic [WIDTH_W-1:0] CNT_ONE = WIDTH_W'(1);

  logic [WIDTH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!hold_i)          cnt_q <= '0;
    else if (fire_i)           cnt_q <= width_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_ONE;
  end

  assign active_o = (cnt_q != '0);

  assert_clear_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> !active_o);
  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && fire_i |=> cnt_q == $past(width_i));
  assert_count_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !fire_i && active_o |=> cnt_q == $past(cnt_q) - CNT_ONE);
  assert_zero_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && fire_i && (width_i == '0) |=> !active_o);
  assert_idle_stays_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i && !active_o |=> !active_o);
endmodule

// File: rtl/os_channel.sv
module os_channel
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_i,
  input  logic               b_i,
  input  logic               clr_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               qn_o
);
  trig_in_t in_s;
  logic     fire_s, hold_s, active_s;

  assign in_s = '{a: a_i, b: b_i, clr: clr_ni};

  os_trig_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_s),
    .fire_o (fire_s),
    .hold_o (hold_s)
  );

  os_pulse_timer #(.WIDTH_W(WIDTH_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire_s),
    .hold_i   (hold_s),
    .width_i  (width_i),
    .active_o (active_s)
  );

  assign q_o  = active_s;
  assign qn_o = ~active_s;
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int NUM_CH  = 2,
  parameter int WIDTH_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         a_i,
  input  logic [NUM_CH-1:0]         b_i,
  input  logic [NUM_CH-1:0]         clr_ni,
  input  logic [NUM_CH*WIDTH_W-1:0] width_i,
  output logic [NUM_CH-1:0]         q_o,
  output logic [NUM_CH-1:0]         qn_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    os_channel #(.WIDTH_W(WIDTH_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_i     (a_i[c]),
      .b_i     (b_i[c]),
      .clr_ni  (clr_ni[c]),
      .width_i (width_i[c*WIDTH_W +: WIDTH_W]),
      .q_o     (q_o[c]),
      .qn_o    (qn_o[c])
    );
  end

  assert_idle_in_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0));
endmodule

// File: tb/tb_dual_oneshot.sv
module tb_dual_oneshot;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int WW  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0] a_v = '1, b_v = '0, c_v = '1;
  logic [NCH*WW-1:0] w_v = '0;
  logic [NCH-1:0] q, qn;

  int n_chk = 0, n_fail = 0;
  string tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_oneshot #(.NUM_CH(NCH), .WIDTH_W(WW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_v), .b_i(b_v), .clr_ni(c_v),
    .width_i(w_v), .q_o(q), .qn_o(qn)
  );

  // behavioural reference
  int m_cnt[NCH];
  bit ra[NCH], pa[NCH], rb[NCH], pb[NCH], rc[NCH], pc[NCH];

  always @(posedge clk or negedge rst_ni) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_ni) begin
        m_cnt[c] = 0;
        ra[c] = 1; pa[c] = 1; rb[c] = 0; pb[c] = 0; rc[c] = 1; pc[c] = 1;
      end else begin
        bit go;
        go = rc[c] && ((pa[c] && !ra[c] && rb[c]) || (!pb[c] && rb[c] && !ra[c]) ||
                       (!pc[c] && !ra[c] && rb[c]));
        if (!rc[c]) m_cnt[c] = 0;
        else if (go) m_cnt[c] = int'(w_v[c*WW +: WW]);
        else if (m_cnt[c] > 0) m_cnt[c] = m_cnt[c] - 1;
        pa[c] = ra[c]; ra[c] = a_v[c];
        pb[c] = rb[c]; rb[c] = b_v[c];
        pc[c] = rc[c]; rc[c] = c_v[c];
      end
    end
  end

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  // every cycle, both channels against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        check(tag, int'(q[c]), int'(m_cnt[c] != 0));
        check("R6", int'(qn[c]), int'(m_cnt[c] == 0));
      end
    end
  end

  task automatic drive(int c, bit a, bit b, bit cl);
    @(negedge clk); #1;
    a_v[c] = a; b_v[c] = b; c_v[c] = cl;
  endtask

  task automatic set_w(int c, int w);
    w_v[c*WW +: WW] = WW'(w);
  endtask

  task automatic count_high(int c, int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (q[c]) k++;
    end
  endtask

  int k;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", int'(q), 0);
    check("R9", int'(qn), 3);
    #1 rst_ni = 1'b1;

    // R1: a falls with b high -> 5-cycle pulse
    tag = "R1";
    set_w(0, 5);
    drive(0, 1, 1, 1);
    drive(0, 0, 1, 1);
    count_high(0, 12, k);
    check("R1", k, 5);
    // R1: a falls with b low -> nothing
    drive(0, 1, 0, 1);
    drive(0, 0, 0, 1);
    count_high(0, 8, k);
    check("R1", k, 0);

    // R2: b rises with a low -> 3 cycles; R6 latency
    tag = "R2";
    set_w(0, 3);
    drive(0, 0, 1, 1);
    @(negedge clk);
    check("R6", int'(q[0]), 0);
    @(negedge clk);
    check("R6", int'(q[0]), 1);
    count_high(0, 8, k);
    check("R2", k, 2);
    // R2: b rises with a high -> nothing
    drive(0, 1, 0, 1);
    drive(0, 1, 1, 1);
    count_high(0, 8, k);
    check("R2", k, 0);

    // R3: retrigger every 3 cycles with width 4 -> 13 contiguous
    tag = "R3";
    set_w(0, 4);
    drive(0, 0, 0, 1);
    for (int r = 0; r < 4; r++) begin
      drive(0, 0, 1, 1);
      drive(0, 0, 0, 1);
      drive(0, 0, 0, 1);
    end
    count_high(0, 20, k);
    k = 0;
    // recount cleanly
    drive(0, 0, 0, 1);
    repeat (6) @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      drive(0, 0, 1, 1);
      if (q[0]) k++;
      drive(0, 0, 0, 1);
      if (q[0]) k++;
      drive(0, 0, 0, 1);
      if (q[0]) k++;
    end
    begin
      int k2;
      count_high(0, 10, k2);
      check("R3", k + k2, 13);
    end

    // R4: clear ends pulse, blocks triggers
    tag = "R4";
    set_w(0, 20);
    drive(0, 0, 1, 1);
    repeat (4) @(negedge clk);
    check("R4", int'(q[0]), 1);
    drive(0, 0, 1, 0);
    @(negedge clk);
    @(negedge clk);
    check("R4", int'(q[0]), 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 1, 0);
    count_high(0, 6, k);
    check("R4", k, 0);

    // R5: clear release with a low, b high -> pulse of 6
    tag = "R5";
    set_w(0, 6);
    drive(0, 0, 1, 1);
    count_high(0, 12, k);
    check("R5", k, 6);

    // R7: zero width
    tag = "R7";
    set_w(0, 0);
    drive(0, 0, 0, 1);
    drive(0, 0, 1, 1);
    count_high(0, 6, k);
    check("R7", k, 0);

    // R8: channel 1 active, channel 0 untouched
    tag = "R8";
    set_w(1, 9);
    drive(1, 1, 1, 1);
    drive(1, 0, 1, 1);
    count_high(0, 12, k);
    check("R8", k, 0);
    check("R8", int'(q[1]), 0);

    // random mix, every cycle compared to the model
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      for (int c = 0; c < NCH; c++) begin
        a_v[c] = ($urandom % 3) == 0 ? ~a_v[c] : a_v[c];
        b_v[c] = ($urandom % 3) == 0 ? ~b_v[c] : b_v[c];
        c_v[c] = ($urandom % 16) != 0;
        if (($urandom % 32) == 0) set_w(c, int'($urandom % 12));
      end
    end
    repeat (20) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule